// File: doc/BRIEF.md
# Segmented Virtual Address Translator with Fault Capture

This block turns a 32-bit virtual address into a physical address using a fixed segment map and the current processor mode. Two kernel windows in the upper half of the address space are translated by subtracting a constant base. The low half of the space, and everything from 0xC0000000 upward, is resolved through an external page-table lookup. That lookup's answer arrives on input ports in the same cycle as the address.

While the error-level flag is set, the low half is passed through unchanged with full access. In user mode, any address with bit 31 set is rejected. Each fault is sorted into one of four classes and given an exception code that depends on the access direction. When a fault coincides with the access-valid strobe, three capture registers are loaded on the next clock edge: the faulting address, a page-table context word and an entry-high word. At all other times the capture registers keep their values.

Translation, permissions, the fault flag and the exception code are all combinational.

Top module: `vaddr_xlate`

## Requirements
- R1: With `user_mode`=1 and `va`[31]=1, the block reports a fault with `refill`=0 and `tlb_req`=0. `exc_code` is 5 for a write (`is_write`=1) and 4 for a read. This check has priority over every other rule.
- R2: For `va` < 0x80000000 with `err_level`=1 and no address error, `pa` equals `va`, both `can_read` and `can_write` are 1, and `tlb_req`=0.
- R3: For `va` in 0x80000000..0x9FFFFFFF with no address error, `pa` = `va` − 0x80000000, both permissions are 1, and `tlb_req`=0.
- R4: For `va` in 0xA0000000..0xBFFFFFFF with no address error, `pa` = `va` − 0xA0000000, both permissions are 1, and `tlb_req`=0.
- R5: A mapped address raises `tlb_req`=1. Mapped means `va` < 0x80000000 with `err_level`=0, or `va` ≥ 0xC0000000. On a valid hit that is not a write to a clean page, `pa` = {`tlb_pfn`, `va`[11:0]}, `can_read`=1 and `can_write`=`tlb_dirty`.
- R6: A mapped access with `tlb_hit`=0 faults with `refill`=1. `exc_code` is 3 for a write and 2 for a read.
- R7: A mapped access with `tlb_hit`=1 and `tlb_valid`=0 faults with `refill`=0. `exc_code` is 3 for a write and 2 for a read.
- R8: A mapped write with `tlb_hit`=1, `tlb_valid`=1 and `tlb_dirty`=0 faults with `exc_code`=1 and `refill`=0.
- R9: Whenever `fault`=1, the outputs `pa`, `can_read` and `can_write` are all 0. Whenever `fault`=0, both `exc_code` and `refill` are 0.
- R10: A clock edge with `fault`=1 and `acc_valid`=1 loads `badva_q` with `va`. The same edge loads `entryhi_q` with {`va`[31:12], 4'b0, `cur_entryhi`[7:0]}.
- R11: The same edge loads `context_q` with {`cur_context`[31:23], `va`[31:13], 4'b0}.
- R12: After reset all three capture registers read 0. On any edge without both `fault` and `acc_valid`, all three keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| va | input | 32 | Virtual address |
| is_write | input | 1 | 1 = store, 0 = load |
| user_mode | input | 1 | Processor is in user mode |
| err_level | input | 1 | Error-level flag; the low half bypasses translation |
| acc_valid | input | 1 | Access strobe that qualifies fault capture |
| tlb_hit | input | 1 | External lookup found a matching entry |
| tlb_valid | input | 1 | The matched entry is valid |
| tlb_dirty | input | 1 | The matched entry is writable |
| tlb_pfn | input | 20 | Page frame number from the lookup |
| cur_context | input | 32 | Present context register value |
| cur_entryhi | input | 32 | Present entry-high register value |
| tlb_req | output | 1 | The address needs the external lookup |
| pa | output | 32 | Physical address |
| can_read | output | 1 | Read permitted |
| can_write | output | 1 | Write permitted |
| fault | output | 1 | The access faults |
| exc_code | output | 5 | Exception code (0 means none) |
| refill | output | 1 | The fault is a lookup miss |
| badva_q | output | 32 | Captured faulting address |
| context_q | output | 32 | Captured context word |
| entryhi_q | output | 32 | Captured entry-high word |

## Verification
The translation outputs, the fault flag, the exception code and `refill` respond in the same cycle as the inputs. The bench therefore drives each access at a falling edge and compares these outputs against its reference model 1 ns later. The capture registers change only at the following rising edge. The bench updates its own register model at that edge and compares the registers at the next falling edge. This includes edges where a fault occurs without the strobe, which must leave the registers unchanged.

// File: rtl/vaddr_xlate.sv
module vaddr_xlate #(
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      va,
  input  logic             is_write,
  input  logic             user_mode,
  input  logic             err_level,
  input  logic             acc_valid,
  input  logic             tlb_hit,
  input  logic             tlb_valid,
  input  logic             tlb_dirty,
  input  logic [PFN_W-1:0] tlb_pfn,
  input  logic [31:0]      cur_context,
  input  logic [31:0]      cur_entryhi,
  output logic             tlb_req,
  output logic [31:0]      pa,
  output logic             can_read,
  output logic             can_write,
  output logic             fault,
  output logic [4:0]       exc_code,
  output logic             refill,
  output logic [31:0]      badva_q,
  output logic [31:0]      context_q,
  output logic [31:0]      entryhi_q
);
  localparam int OFF_W = 32 - PFN_W;
  localparam logic [4:0] EXC_NONE = 5'd0;
  localparam logic [4:0] EXC_MOD  = 5'd1;
  localparam logic [4:0] EXC_TLBL = 5'd2;
  localparam logic [4:0] EXC_TLBS = 5'd3;
  localparam logic [4:0] EXC_ADEL = 5'd4;
  localparam logic [4:0] EXC_ADES = 5'd5;

  logic addr_err, low_half, win_k0, win_k1, bypass_low;
  logic capture;

  assign low_half   = ~va[31];
  assign win_k0     = va[31:29] == 3'b100;
  assign win_k1     = va[31:29] == 3'b101;
  assign addr_err   = user_mode & va[31];
  assign bypass_low = low_half & err_level;
  assign tlb_req    = ~addr_err & ~bypass_low & ~win_k0 & ~win_k1;

  always_comb begin
    pa        = '0;
    can_read  = 1'b0;
    can_write = 1'b0;
    exc_code  = EXC_NONE;
    refill    = 1'b0;
    if (addr_err) begin
      exc_code = is_write ? EXC_ADES : EXC_ADEL;
    end else if (bypass_low) begin
      pa        = va;
      can_read  = 1'b1;
      can_write = 1'b1;
    end else if (win_k0 || win_k1) begin
      pa        = {3'b000, va[28:0]};
      can_read  = 1'b1;
      can_write = 1'b1;
    end else if (!tlb_hit) begin
      exc_code = is_write ? EXC_TLBS : EXC_TLBL;
      refill   = 1'b1;
    end else if (!tlb_valid) begin
      exc_code = is_write ? EXC_TLBS : EXC_TLBL;
    end else if (is_write && !tlb_dirty) begin
      exc_code = EXC_MOD;
    end else begin
      pa        = {tlb_pfn, va[OFF_W-1:0]};
      can_read  = 1'b1;
      can_write = tlb_dirty;
    end
  end

  assign fault   = exc_code != EXC_NONE;
  assign capture = fault & acc_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badva_q   <= '0;
      context_q <= '0;
      entryhi_q <= '0;
    end else if (capture) begin
      badva_q   <= va;
      context_q <= {cur_context[31:23], va[31:13], 4'b0000};
      entryhi_q <= {va[31:12], {(12-ASID_W){1'b0}}, cur_entryhi[ASID_W-1:0]};
    end
  end

  p_ade_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && va[31]) |-> (fault && !tlb_req && exc_code == (is_write ? 5'd5 : 5'd4)));

  p_k0_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_mode && va[31:29] == 3'b100) |-> (!tlb_req && !fault && pa[31:29] == 3'b000));

  p_refill_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refill |-> (fault && tlb_req && !tlb_hit));

  p_mod_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_code == 5'd1) |-> (is_write && tlb_hit && !tlb_dirty));

  p_fault_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (pa == 32'd0 && !can_read && !can_write));

  p_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && acc_valid) |=> (badva_q == $past(va)));

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && acc_valid) |=> ($stable(badva_q) && $stable(context_q) && $stable(entryhi_q)));
endmodule

// File: tb/vaddr_xlate_bench.sv
module vaddr_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] va = '0;
  logic        is_write = 1'b0, user_mode = 1'b0, err_level = 1'b0, acc_valid = 1'b0;
  logic        tlb_hit = 1'b0, tlb_valid = 1'b0, tlb_dirty = 1'b0;
  logic [19:0] tlb_pfn = '0;
  logic [31:0] cur_context = '0, cur_entryhi = '0;
  logic        tlb_req, can_read, can_write, fault, refill;
  logic [31:0] pa, badva_q, context_q, entryhi_q;
  logic [4:0]  exc_code;

  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  logic [31:0] m_bad = '0, m_ctx = '0, m_ehi = '0;

  always #5 clk = ~clk;

  vaddr_xlate u_vaddr_xlate (
    .clk(clk), .rst_n(rst_n), .va(va), .is_write(is_write), .user_mode(user_mode),
    .err_level(err_level), .acc_valid(acc_valid), .tlb_hit(tlb_hit), .tlb_valid(tlb_valid),
    .tlb_dirty(tlb_dirty), .tlb_pfn(tlb_pfn), .cur_context(cur_context),
    .cur_entryhi(cur_entryhi), .tlb_req(tlb_req), .pa(pa), .can_read(can_read),
    .can_write(can_write), .fault(fault), .exc_code(exc_code), .refill(refill),
    .badva_q(badva_q), .context_q(context_q), .entryhi_q(entryhi_q)
  );

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic model(output string rq, output bit e_req, output logic [31:0] e_pa,
                       output bit e_rd, output bit e_wr, output int e_code, output bit e_rf);
    longint unsigned a;
    a = va;
    e_req = 0; e_pa = 0; e_rd = 0; e_wr = 0; e_code = 0; e_rf = 0;
    if (user_mode && a >= 64'h8000_0000) begin
      rq = "R1"; e_code = is_write ? 5 : 4;
    end else if (a < 64'h8000_0000 && err_level) begin
      rq = "R2"; e_pa = va; e_rd = 1; e_wr = 1;
    end else if (a >= 64'h8000_0000 && a < 64'hA000_0000) begin
      rq = "R3"; e_pa = 32'(a - 64'h8000_0000); e_rd = 1; e_wr = 1;
    end else if (a >= 64'hA000_0000 && a < 64'hC000_0000) begin
      rq = "R4"; e_pa = 32'(a - 64'hA000_0000); e_rd = 1; e_wr = 1;
    end else begin
      e_req = 1;
      if (!tlb_hit) begin
        rq = "R6"; e_code = is_write ? 3 : 2; e_rf = 1;
      end else if (!tlb_valid) begin
        rq = "R7"; e_code = is_write ? 3 : 2;
      end else if (is_write && !tlb_dirty) begin
        rq = "R8"; e_code = 1;
      end else begin
        rq = "R5"; e_pa = (32'(tlb_pfn) * 4096) + (va % 4096); e_rd = 1; e_wr = tlb_dirty;
      end
    end
  endtask

  task automatic step(input logic [31:0] a, input bit w, input bit um, input bit el, input bit av,
                      input bit hit, input bit vld, input bit dty, input logic [19:0] pfn,
                      input logic [31:0] cctx, input logic [31:0] cehi);
    string rq;
    bit e_req, e_rd, e_wr, e_rf;
    logic [31:0] e_pa;
    int e_code;
    va = a; is_write = w; user_mode = um; err_level = el; acc_valid = av;
    tlb_hit = hit; tlb_valid = vld; tlb_dirty = dty; tlb_pfn = pfn;
    cur_context = cctx; cur_entryhi = cehi;
    #1;
    model(rq, e_req, e_pa, e_rd, e_wr, e_code, e_rf);
    chk(rq, "tlb_req", 32'(tlb_req), 32'(e_req));
    chk(rq, "pa", pa, e_pa);
    chk(rq, "can_read", 32'(can_read), 32'(e_rd));
    chk(rq, "can_write", 32'(can_write), 32'(e_wr));
    chk(rq, "exc_code", 32'(exc_code), 32'(e_code));
    chk(rq, "refill", 32'(refill), 32'(e_rf));
    chk("R9", "fault", 32'(fault), 32'(e_code != 0));
    @(posedge clk);
    if (e_code != 0 && av) begin
      m_bad = a;
      m_ctx = (cctx & 32'hFF80_0000) | ((a >> 9) & 32'h007F_FFF0);
      m_ehi = (cehi & 32'h0000_00FF) | (a & 32'hFFFF_F000);
    end
    @(negedge clk);
    chk("R10", "badva_q", badva_q, m_bad);
    chk("R11", "context_q", context_q, m_ctx);
    chk("R10", "entryhi_q", entryhi_q, m_ehi);
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "reset badva_q", badva_q, 0);
    chk("R12", "reset context_q", context_q, 0);
    chk("R12", "reset entryhi_q", entryhi_q, 0);
    // R1 user access to upper half, read and write, with capture
    step(32'h8000_1234, 0, 1, 0, 1, 1, 1, 1, 20'h12345, 32'hABCD_EF01, 32'h1111_11A5);
    step(32'hC000_5678, 1, 1, 0, 1, 1, 1, 1, 20'h12345, 32'h0123_4567, 32'h0000_0042);
    // R2 error-level identity
    step(32'h7FFF_FFFC, 1, 0, 1, 1, 0, 0, 0, 20'h0, 32'h0, 32'h0);
    step(32'h0000_0000, 0, 1, 1, 1, 0, 0, 0, 20'h0, 32'h0, 32'h0);
    // R3 / R4 window edges
    step(32'h8000_0000, 0, 0, 0, 1, 0, 0, 0, 20'h0, 32'h0, 32'h0);
    step(32'h9FFF_FFFF, 1, 0, 0, 1, 0, 0, 0, 20'h0, 32'h0, 32'h0);
    step(32'hA000_0000, 0, 0, 0, 1, 0, 0, 0, 20'h0, 32'h0, 32'h0);
    step(32'hBFFF_FFFF, 1, 0, 0, 1, 0, 0, 0, 20'h0, 32'h0, 32'h0);
    // R5 mapped hits
    step(32'hC000_0ABC, 1, 0, 0, 1, 1, 1, 1, 20'hFEDCB, 32'h0, 32'h0);
    step(32'h1234_5678, 0, 0, 0, 1, 1, 1, 0, 20'h00077, 32'h0, 32'h0);
    step(32'hFFFF_FFFF, 0, 0, 0, 1, 1, 1, 1, 20'h00001, 32'h0, 32'h0);
    // R6 miss, R7 invalid, R8 clean write, all captured
    step(32'h0040_3000, 0, 0, 0, 1, 0, 0, 0, 20'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(32'hE000_2004, 1, 0, 0, 1, 0, 1, 1, 20'h0, 32'h0080_0000, 32'h0000_0F00);
    step(32'h7FFF_E000, 1, 0, 0, 1, 1, 0, 1, 20'h0, 32'h5555_5555, 32'hAAAA_AAAA);
    step(32'h0000_1FFF, 0, 0, 0, 1, 1, 0, 0, 20'h0, 32'h0, 32'h0);
    step(32'hD123_4567, 1, 0, 0, 1, 1, 1, 0, 20'h0, 32'h1234_5678, 32'h0000_00EE);
    // R12 fault without strobe: registers must hold
    step(32'h0BAD_0000, 1, 0, 0, 0, 0, 0, 0, 20'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    step(32'hFFFF_0000, 0, 1, 0, 0, 0, 0, 0, 20'h0, 32'h0, 32'h0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r, 1'($urandom), 1'($urandom % 4 == 0), 1'($urandom % 4 == 0), 1'($urandom % 3 != 0),
           1'($urandom % 4 != 0), 1'($urandom % 4 != 0), 1'($urandom), 20'($urandom),
           $urandom, $urandom);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule